// File: doc/BRIEF.md
# SerDes Control-Register Window Bridge

This block gives a single read/write request port to the control registers inside a SerDes. The SerDes does not map those registers straight onto the bus. Each internal register is reached in two levels. First a page word naming the device and the upper address bits is written to a fixed select register of a memory window. Then the register is accessed at its offset inside that window. The SerDes control registers sit behind a further indirect handshake. A control register carries a busy/start bit and a direction bit, an address register holds the target, and a data register holds the value.

For each accepted request the bridge polls busy until it clears, loads the target address, and starts the operation. A write places its data in the data register before the start and does not wait for the operation to finish. A read polls busy again and then returns the data register. A polled busy bit is re-read only after a programmable idle gap. A poll count limit ends a request with an error when busy never clears. Requests are taken one at a time, so no page-select write of one request can fall between another request's page write and its register access.

Top module: `serdes_cr_bridge`

## Requirements
- R1: After reset, req_ready is 1, mm_req is 0 and rsp_valid is 0.
- R2: Every access to a windowed register comes directly after a bus write to byte offset 0x800. That write carries the page word {dev[4:0], iaddr[15:9]}, which is (dev<<7)|((iaddr>>9)&0x7F).
- R3: The windowed access uses byte offset {iaddr[8:0],2'b00}. The control, address and data registers are at internal addresses 0x80A0, 0x80A1 and 0x80A2, so they land at offsets 0x280, 0x284 and 0x288 with page low bits 0x40. The bridge makes no other windowed access.
- R4: A read runs in this order: poll the control register until bit 0 (busy) is 0, write the target address to the address register, write 0x1 to control, poll again, then read the data register. It returns that word on rsp_rdata with rsp_err=0.
- R5: A write runs in this order: poll until not busy, write the address register, write the data register, then write 0x3 to control (bit 1 = write, bit 0 = start). rsp_valid follows two cycles after that bus write is acknowledged, with no further poll.
- R6: After a poll that reads busy=1, at least POLL_GAP cycles pass before the next poll is acknowledged.
- R7: If POLL_LIMIT consecutive polls in one wait phase read busy=1, the request ends with rsp_valid=1, rsp_err=1 and rsp_rdata=0. It makes no further bus transfer.
- R8: req_ready is 1 only while no request is in progress. A req_valid seen while req_ready is 0 is ignored.
- R9: Once mm_req is raised, it stays high with mm_addr, mm_we and mm_wdata unchanged until mm_ack is seen.
- R10: Each accepted request yields exactly one rsp_valid pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle; a request is taken in a cycle where req_valid and req_ready are both 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | SerDes device number |
| req_addr | input | 16 | Internal control-register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request aborted by poll timeout |
| rsp_rdata | output | DATA_W | Read result (0 for writes and errors) |
| mm_req | output | 1 | Bus transfer pending |
| mm_we | output | 1 | Bus transfer is a write |
| mm_addr | output | 12 | Byte offset inside the window |
| mm_wdata | output | DATA_W | Bus write data |
| mm_ack | input | 1 | Transfer done; mm_rdata valid with it |
| mm_rdata | input | DATA_W | Bus read data |

## Verification
The assertions assume a well-behaved bus. mm_ack rises only while mm_req is high, and it falls the cycle after, so each transfer is acknowledged exactly once. The bench's bus model honours this by acknowledging one cycle after it sees a pending transfer, and never in the cycle right after an acknowledge. The assertions also rely on req_valid mattering only when req_ready is high. The bench offers one deliberate request while the bridge is busy, to show it is dropped. It keeps every other busy phase shorter than POLL_LIMIT, except in the timeout case.

// File: rtl/serdes_cr_pkg.sv
package serdes_cr_pkg;

  localparam int MM_AW   = 12;
  localparam int DEV_W   = 5;
  localparam int IADDR_W = 16;

  localparam logic [MM_AW-1:0]   WIN_SEL_OFF = 12'h800;
  localparam logic [IADDR_W-1:0] CR_CTL_IA   = 16'h80A0;
  localparam logic [IADDR_W-1:0] CR_ADR_IA   = 16'h80A1;
  localparam logic [IADDR_W-1:0] CR_DAT_IA   = 16'h80A2;

  localparam int CTL_BUSY_GO = 0;
  localparam int CTL_DIR_WR  = 1;

  // page word placed in the window select register
  function automatic logic [MM_AW-1:0] page_word(input logic [DEV_W-1:0] dev,
                                                 input logic [IADDR_W-1:0] ia);
    return {dev, ia[15:9]};
  endfunction

  // byte offset of an internal register inside the window
  function automatic logic [MM_AW-1:0] win_offset(input logic [IADDR_W-1:0] ia);
    return {1'b0, ia[8:0], 2'b00};
  endfunction

  typedef enum logic [1:0] {LK_IDLE, LK_PAGE, LK_REG} lk_phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_POLL, SQ_GAP, SQ_ADDR, SQ_DATA, SQ_KICK, SQ_FETCH
  } sq_state_t;

  typedef struct packed {
    logic                we;
    logic [IADDR_W-1:0]  ia;
  } cr_op_t;

endpackage

// File: rtl/serdes_cr_link.sv
module serdes_cr_link
  import serdes_cr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_go,
  input  cr_op_t             op_cmd,
  input  logic [DATA_W-1:0]  op_wdata,
  input  logic [DEV_W-1:0]   op_dev,
  output logic               op_done,
  output logic [DATA_W-1:0]  op_rdata,
  output logic               mm_req,
  output logic               mm_we,
  output logic [MM_AW-1:0]   mm_addr,
  output logic [DATA_W-1:0]  mm_wdata,
  input  logic               mm_ack,
  input  logic [DATA_W-1:0]  mm_rdata
);

  lk_phase_t          phase;
  cr_op_t             r_cmd;
  logic [DATA_W-1:0]  r_wdata;
  logic [DEV_W-1:0]   r_dev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= LK_IDLE;
      r_cmd    <= '0;
      r_wdata  <= '0;
      r_dev    <= '0;
      op_done  <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= 1'b0;
      case (phase)
        LK_IDLE: if (op_go) begin
          r_cmd   <= op_cmd;
          r_wdata <= op_wdata;
          r_dev   <= op_dev;
          phase   <= LK_PAGE;
        end
        LK_PAGE: if (mm_ack) phase <= LK_REG;
        LK_REG: if (mm_ack) begin
          op_rdata <= mm_rdata;
          op_done  <= 1'b1;
          phase    <= LK_IDLE;
        end
        default: phase <= LK_IDLE;
      endcase
    end
  end

  always_comb begin
    mm_req   = (phase != LK_IDLE);
    mm_we    = (phase == LK_PAGE) | r_cmd.we;
    mm_addr  = (phase == LK_PAGE) ? WIN_SEL_OFF : win_offset(r_cmd.ia);
    mm_wdata = (phase == LK_PAGE) ? DATA_W'(page_word(r_dev, r_cmd.ia)) : r_wdata;
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req && !mm_ack |=> mm_req && $stable(mm_addr) && $stable(mm_we) && $stable(mm_wdata)); // R9

  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |-> !mm_req); // R8

endmodule

// File: rtl/serdes_cr_seq.sv
module serdes_cr_seq
  import serdes_cr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POLL_GAP   = 500,
  parameter int POLL_LIMIT = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [IADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               op_go,
  output cr_op_t             op_cmd,
  output logic [DATA_W-1:0]  op_wdata,
  output logic [DEV_W-1:0]   op_dev,
  input  logic               op_done,
  input  logic [DATA_W-1:0]  op_rdata,
  output logic               busy_seen,
  output logic               timeout_ev
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int GCW = $clog2(POLL_GAP + 1);

  sq_state_t           state;
  logic                issued;
  logic                after_kick;
  logic                r_write;
  logic [IADDR_W-1:0]  r_addr;
  logic [DATA_W-1:0]   r_wdata;
  logic [PCW-1:0]      poll_cnt;
  logic [GCW-1:0]      gap_cnt;
  logic                step;

  assign step       = (state == SQ_POLL) || (state == SQ_ADDR) || (state == SQ_DATA) ||
                      (state == SQ_KICK) || (state == SQ_FETCH);
  assign op_go      = step && !issued;
  assign req_ready  = (state == SQ_IDLE);
  assign busy_seen  = op_done && (state == SQ_POLL) && op_rdata[CTL_BUSY_GO];
  assign timeout_ev = busy_seen && (poll_cnt == PCW'(POLL_LIMIT - 1));

  always_comb begin
    op_cmd   = '{we: 1'b0, ia: CR_CTL_IA};
    op_wdata = '0;
    case (state)
      SQ_ADDR: begin
        op_cmd   = '{we: 1'b1, ia: CR_ADR_IA};
        op_wdata = DATA_W'(r_addr);
      end
      SQ_DATA: begin
        op_cmd   = '{we: 1'b1, ia: CR_DAT_IA};
        op_wdata = r_wdata;
      end
      SQ_KICK: begin
        op_cmd   = '{we: 1'b1, ia: CR_CTL_IA};
        op_wdata = '0;
        op_wdata[CTL_BUSY_GO] = 1'b1;
        op_wdata[CTL_DIR_WR]  = r_write;
      end
      SQ_FETCH: op_cmd = '{we: 1'b0, ia: CR_DAT_IA};
      default:  op_cmd = '{we: 1'b0, ia: CR_CTL_IA};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      issued     <= 1'b0;
      after_kick <= 1'b0;
      r_write    <= 1'b0;
      op_dev     <= '0;
      r_addr     <= '0;
      r_wdata    <= '0;
      poll_cnt   <= '0;
      gap_cnt    <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (op_go) issued <= 1'b1;
      case (state)
        SQ_IDLE: if (req_valid) begin
          r_write    <= req_write;
          op_dev     <= req_dev;
          r_addr     <= req_addr;
          r_wdata    <= req_wdata;
          after_kick <= 1'b0;
          poll_cnt   <= '0;
          issued     <= 1'b0;
          state      <= SQ_POLL;
        end
        SQ_POLL: if (op_done) begin
          issued <= 1'b0;
          if (timeout_ev) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            state     <= SQ_IDLE;
          end else if (busy_seen) begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= '0;
            state    <= SQ_GAP;
          end else begin
            poll_cnt <= '0;
            state    <= after_kick ? SQ_FETCH : SQ_ADDR;
          end
        end
        SQ_GAP: begin
          if (gap_cnt == GCW'(POLL_GAP - 1)) state <= SQ_POLL;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        SQ_ADDR: if (op_done) begin
          issued <= 1'b0;
          state  <= r_write ? SQ_DATA : SQ_KICK;
        end
        SQ_DATA: if (op_done) begin
          issued <= 1'b0;
          state  <= SQ_KICK;
        end
        SQ_KICK: if (op_done) begin
          issued <= 1'b0;
          if (r_write) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            state     <= SQ_IDLE;
          end else begin
            after_kick <= 1'b1;
            state      <= SQ_POLL;
          end
        end
        SQ_FETCH: if (op_done) begin
          issued    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= op_rdata;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PCW'(POLL_LIMIT)); // R7

  AST_TIMEOUT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> rsp_valid && rsp_err && (rsp_rdata == '0)); // R7

endmodule

// File: rtl/serdes_cr_bridge.sv
module serdes_cr_bridge
  import serdes_cr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POLL_GAP   = 500,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_dev,
  input  logic [15:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mm_req,
  output logic              mm_we,
  output logic [11:0]       mm_addr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic              mm_ack,
  input  logic [DATA_W-1:0] mm_rdata
);

  logic              op_go;
  cr_op_t            op_cmd;
  logic [DATA_W-1:0] op_wdata;
  logic [DEV_W-1:0]  op_dev;
  logic              op_done;
  logic [DATA_W-1:0] op_rdata;
  logic              busy_seen;
  logic              timeout_ev;

  serdes_cr_seq #(
    .DATA_W(DATA_W), .POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .op_go(op_go), .op_cmd(op_cmd), .op_wdata(op_wdata), .op_dev(op_dev),
    .op_done(op_done), .op_rdata(op_rdata),
    .busy_seen(busy_seen), .timeout_ev(timeout_ev)
  );

  serdes_cr_link #(.DATA_W(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .op_go(op_go), .op_cmd(op_cmd), .op_wdata(op_wdata), .op_dev(op_dev),
    .op_done(op_done), .op_rdata(op_rdata),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_ack(mm_ack), .mm_rdata(mm_rdata)
  );

  // last acknowledged transfer was a page-select write
  logic page_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) page_seen <= 1'b0;
    else if (mm_req && mm_ack) page_seen <= (mm_addr == WIN_SEL_OFF);
  end

  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req && (mm_addr != WIN_SEL_OFF) |-> page_seen); // R2

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mm_req && !busy_seen); // R8

  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req && mm_ack && mm_we && (mm_addr == win_offset(CR_CTL_IA)) &&
    mm_wdata[CTL_DIR_WR] && mm_wdata[CTL_BUSY_GO] |-> ##2 rsp_valid); // R5

endmodule

// File: tb/test_serdes_cr_bridge.sv
module test_serdes_cr_bridge;

  localparam int DW    = 32;
  localparam int GAP   = 10;
  localparam int LIMIT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [4:0]    req_dev = '0;
  logic [15:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          mm_req, mm_we;
  logic [11:0]   mm_addr;
  logic [DW-1:0] mm_wdata;
  logic          mm_ack = 1'b0;
  logic [DW-1:0] mm_rdata = '0;

  always #5 clk = ~clk;

  serdes_cr_bridge #(.DATA_W(DW), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) i_serdes_cr_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_ack(mm_ack), .mm_rdata(mm_rdata)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- SerDes-side bus model ----------------
  logic [11:0]   page = '0;
  bit            win_ok = 0;
  logic [15:0]   ireg_addr = '0;
  logic [DW-1:0] ireg_data = '0;
  logic [DW-1:0] sd_mem [int];
  int  busy_left = 0, busy_len = 0;
  bit  stuck = 0;
  logic [4:0] cur_dev = '0;
  int  trans_cnt = 0, page_bad = 0, reg_bad = 0;
  int  gap_bad = 0, gap_seen = 0, last_busy_cyc = 0, ctlw_cyc = 0;
  bit  prev_busy = 0;

  always @(posedge clk) begin
    if (!rst_n) mm_ack <= 1'b0;
    else begin
      mm_ack <= 1'b0;
      if (mm_req && !mm_ack) begin
        logic [15:0] ia;
        int key;
        mm_ack   <= 1'b1;
        mm_rdata <= '0;
        trans_cnt = trans_cnt + 1;
        if (mm_addr == 12'h800) begin
          if (!mm_we) page_bad = page_bad + 1;
          page   = mm_wdata[11:0];
          win_ok = 1;
        end else begin
          if (!win_ok || page[11:7] != cur_dev) page_bad = page_bad + 1;
          win_ok = 0;
          if (mm_addr[1:0] != 2'b00) reg_bad = reg_bad + 1;
          ia  = {page[6:0], mm_addr[10:2]};
          key = int'({page[11:7], ireg_addr});
          if (ia == 16'h80A0 && !mm_we) begin
            if (prev_busy) begin
              gap_seen = gap_seen + 1;
              if (cyc - last_busy_cyc < GAP) gap_bad = gap_bad + 1;
            end
            if (stuck || busy_left > 0) begin
              mm_rdata <= 32'h1;
              if (!stuck) busy_left = busy_left - 1;
              prev_busy = 1;
              last_busy_cyc = cyc;
            end else prev_busy = 0;
          end else if (ia == 16'h80A0 && mm_we) begin
            if (mm_wdata[0]) begin
              if (mm_wdata[1]) sd_mem[key] = ireg_data;
              else ireg_data = sd_mem.exists(key) ? sd_mem[key] : '0;
              busy_left = busy_len;
              ctlw_cyc  = cyc;
            end
          end else if (ia == 16'h80A1 && mm_we) ireg_addr = mm_wdata[15:0];
          else if (ia == 16'h80A2 && mm_we) ireg_data = mm_wdata;
          else if (ia == 16'h80A2 && !mm_we) mm_rdata <= ireg_data;
          else reg_bad = reg_bad + 1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit            wr;
    bit            err;
    logic [DW-1:0] rd;
    int            trans;
    int            base;
  } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] shadow [int];
  int sent = 0, rsp_cnt = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                      input logic [DW-1:0] d);
    exp_t e;
    int key;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    key     = int'({dev, a});
    e.wr    = wr;
    e.base  = trans_cnt;
    if (stuck) begin
      e.err = 1; e.rd = '0; e.trans = 2 * LIMIT;
    end else begin
      e.err   = 0;
      e.rd    = wr ? '0 : (shadow.exists(key) ? shadow[key] : '0);
      e.trans = wr ? 8 + 2 * busy_left : 10 + 2 * (busy_left + busy_len);
      if (wr) shadow[key] = d;
    end
    exp_q.push_back(e);
    cur_dev   = dev;
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = d;
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        if (rsp_valid) begin
          exp_t e;
          rsp_cnt++;
          if (exp_q.size() == 0) chk("R10 unexpected response", 1, 0);
          else begin
            e = exp_q.pop_front();
            chk("R7 rsp_err", rsp_err, e.err);
            chk(e.wr ? "R5 write rdata" : "R4 read data", rsp_rdata, e.rd);
            chk(e.wr ? "R5 bus transfer count" : "R4 bus transfer count",
                trans_cnt - e.base, e.trans);
            chk("R8 ready with response", req_ready, 1'b1);
            if (e.wr && !e.err) chk("R5 response latency", cyc - ctlw_cyc, 3);
          end
        end
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 mm_req", mm_req, 1'b0);
    chk("R1 rsp_valid", rsp_valid, 1'b0);

    // no busy delay
    busy_len = 0;
    send(1, 5'd3,  16'h1234, 32'hBEEF_0001);
    send(0, 5'd3,  16'h1234, '0);
    send(1, 5'd31, 16'hFFFF, 32'h5A5A_5A5A);
    send(0, 5'd31, 16'hFFFF, '0);
    send(0, 5'd7,  16'h0005, '0);

    // busy for two polls after every start
    wait_idle();
    busy_len = 2;
    send(1, 5'd5, 16'h0200, 32'h1111_2222);
    send(0, 5'd5, 16'h0200, '0);
    send(0, 5'd3, 16'h1234, '0);

    // R8: request offered while busy must be dropped
    send(1, 5'd9, 16'h0040, 32'hCAFE_0000);
    req_valid = 1'b1; req_write = 1'b1; req_dev = 5'd9; req_addr = 16'h0040;
    req_wdata = 32'hDEAD_DEAD;
    @(negedge clk);
    req_valid = 1'b0;
    send(0, 5'd9, 16'h0040, '0);

    // R7: busy never clears
    wait_idle();
    stuck = 1;
    send(0, 5'd2, 16'h0100, '0);
    wait_idle();
    begin
      int t0;
      t0 = trans_cnt;
      repeat (20) @(negedge clk);
      chk("R7 no transfer after timeout", trans_cnt - t0, 0);
    end
    stuck = 0;
    send(0, 5'd9, 16'h0040, '0);

    wait_idle();
    chk("R2 page write before each access", page_bad, 0);
    chk("R3 windowed offsets", reg_bad, 0);
    chk("R6 poll gap respected", gap_bad, 0);
    chk("R6 busy retries exercised", gap_seen > 0, 1'b1);
    chk("R10 one response per request", rsp_cnt, sent);
    chk("R9 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule